// File: doc/BRIEF.md
# Configurable-Frame Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A host hands it one parallel word at a time over a valid/ready transmit port and the block shifts it out on a single line as a framed character. At the same time the block watches an incoming line, rebuilds characters from it and presents each one for a single cycle, with separate flags for a bad parity bit and a bad stop bit.

The character format is chosen at run time through three inputs: how many data bits (5 to 9), whether a parity bit follows (none, even or odd) and whether one or two stop bits close the character. Bit timing comes from a divisor on the system clock: one oversampling tick every `cfg_div` clocks, sixteen ticks to a bit. Each direction copies the format and the divisor when a character starts, so the host may change them while a character is in flight.

Top module: `uart_xcvr`

## Requirements
- R1: After reset and between characters `tx_line` is high, `tx_ready` is high and `rx_valid` is low.
- R2: An accepted word (`tx_valid` and `tx_ready` high at a clock edge) drives `tx_line` low from that edge for one bit time (the start bit), then sends the low `cfg_len` bits of `tx_data` least significant first, then the optional parity bit, then one stop bit (or two when `cfg_stop2` is 1) at high level; every bit lasts 16 × `cfg_div` clocks.
- R3: `cfg_par` encodes 00 = no parity bit, 01 = even (data ones plus parity bit give an even count), 10 = odd (the count is odd); 11 is treated as no parity.
- R4: `tx_ready` is low from the cycle after acceptance until the end of the last stop bit; `tx_valid` and `tx_data` have no effect on the character in flight.
- R5: Format and divisor are captured when a character begins in either direction; changes to the configuration inputs during that character do not alter it.
- R6: A high-to-low transition of the synchronised receive line starts a character; the line is resampled eight ticks later and then every sixteen ticks; the received bits appear right-aligned on `rx_data` (upper bits zero) with a one-cycle `rx_valid` pulse after the last stop sample.
- R7: A low pulse on `rx_line` that has ended by the mid-start-bit resample produces no `rx_valid`, and the next proper character is received correctly.
- R8: `rx_par_err` is high with `rx_valid` when parity is enabled and the received parity bit disagrees with the received data under the selected mode; it is low for a correct parity bit.
- R9: `rx_frm_err` is high with `rx_valid` when any sampled stop bit, including the second in two-stop mode, is low.
- R10: Characters of 8 data bits, no parity, one stop bit are received correctly when the sender's bit time is up to 3 % shorter or longer than the receiver's.
- R11: `rx_par_err` and `rx_frm_err` are low in every cycle where `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Clocks per oversampling tick (0 treated as 1) |
| cfg_len | input | 4 | Data bits per character, clamped to 5..9 |
| cfg_par | input | 2 | Parity mode: 00 none, 01 even, 10 odd |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_data | input | 9 | Word to send, right-aligned |
| tx_valid | input | 1 | Word on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 9 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse: a character has ended |
| rx_par_err | output | 1 | Parity mismatch on this character |
| rx_frm_err | output | 1 | A stop bit was sampled low |

## Verification
The transmitter is tried with a short 5-bit character under even parity, a full 9-bit character under odd parity with two stops, and a plain 8-bit character, so that bit order, length clamping, parity sense and stop count are each told apart by the sampled line. The receiver gets the same spread of formats plus a corrupted parity bit, a low first stop and a low second stop, which separates the two error flags and shows the second stop is really checked. A short low pulse distinguishes glitch rejection from a start, and bit times 3 % short and long show that mid-bit sampling absorbs drift. Configuration changes in mid-character, and a word offered while busy, show that both directions hold the format they captured.

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int DIV_W = 16,
  parameter int OSR   = 16,
  parameter int DW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [3:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_stop2,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_line,
  input  logic             rx_line,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic             rx_par_err,
  output logic             rx_frm_err
);

  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
  localparam logic [TW-1:0] T_MID  = TW'(OSR / 2 - 1);
  localparam logic [3:0]    LEN_MIN = 4'd5;
  localparam logic [3:0]    LEN_MAX = 4'(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;

  function automatic logic [3:0] clamp_len(input logic [3:0] l);
    if (l < LEN_MIN) return LEN_MIN;
    if (l > LEN_MAX) return LEN_MAX;
    return l;
  endfunction

  wire [3:0]       c_len    = clamp_len(cfg_len);
  wire             c_par_on = (cfg_par == 2'b01) || (cfg_par == 2'b10);
  wire             c_odd    = (cfg_par == 2'b10);
  wire [DIV_W-1:0] c_div    = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  wire [DW-1:0]    c_mask   = ~({DW{1'b1}} << c_len);

  // transmit side
  st_e              t_st;
  logic [DIV_W-1:0] t_div, t_dcnt;
  logic [TW-1:0]    t_tcnt;
  logic [DW-1:0]    t_sh;
  logic [3:0]       t_len, t_bit;
  logic             t_par_on, t_pbit, t_stop2, t_second;

  wire t_tick    = (t_dcnt == t_div - 1'b1);
  wire t_bit_end = t_tick && (t_tcnt == T_LAST);

  assign tx_ready = (t_st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_st     <= S_IDLE;
      tx_line  <= 1'b1;
      t_div    <= DIV_W'(1);
      t_dcnt   <= '0;
      t_tcnt   <= '0;
      t_sh     <= '0;
      t_len    <= LEN_MIN;
      t_bit    <= '0;
      t_par_on <= 1'b0;
      t_pbit   <= 1'b0;
      t_stop2  <= 1'b0;
      t_second <= 1'b0;
    end else if (t_st == S_IDLE) begin
      t_dcnt <= '0;
      t_tcnt <= '0;
      if (tx_valid) begin
        t_st     <= S_START;
        tx_line  <= 1'b0;
        t_div    <= c_div;
        t_sh     <= tx_data & c_mask;
        t_len    <= c_len;
        t_par_on <= c_par_on;
        t_pbit   <= (^(tx_data & c_mask)) ^ c_odd;
        t_stop2  <= cfg_stop2;
        t_second <= 1'b0;
      end
    end else begin
      t_dcnt <= t_tick ? '0 : t_dcnt + 1'b1;
      if (t_tick) t_tcnt <= (t_tcnt == T_LAST) ? '0 : t_tcnt + 1'b1;
      if (t_bit_end) begin
        case (t_st)
          S_START: begin
            tx_line <= t_sh[0];
            t_sh    <= t_sh >> 1;
            t_bit   <= 4'd1;
            t_st    <= S_DATA;
          end
          S_DATA: begin
            if (t_bit == t_len) begin
              if (t_par_on) begin
                tx_line <= t_pbit;
                t_st    <= S_PAR;
              end else begin
                tx_line <= 1'b1;
                t_st    <= S_STOP;
              end
            end else begin
              tx_line <= t_sh[0];
              t_sh    <= t_sh >> 1;
              t_bit   <= t_bit + 1'b1;
            end
          end
          S_PAR: begin
            tx_line <= 1'b1;
            t_st    <= S_STOP;
          end
          S_STOP: begin
            if (t_stop2 && !t_second) t_second <= 1'b1;
            else                      t_st     <= S_IDLE;
          end
          default: t_st <= S_IDLE;
        endcase
      end
    end
  end

  // receive side
  st_e              r_st;
  logic             r_s1, r_s2, r_prev;
  logic [DIV_W-1:0] r_div, r_dcnt;
  logic [TW-1:0]    r_tcnt;
  logic [DW-1:0]    r_sh;
  logic [3:0]       r_len, r_bit;
  logic             r_par_on, r_odd, r_pbit, r_stop2, r_second, r_ferr;

  wire r_fall = r_prev && !r_s2;
  wire r_tick = (r_dcnt == r_div - 1'b1);
  wire r_pexp = (^r_sh) ^ r_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_s1       <= 1'b1;
      r_s2       <= 1'b1;
      r_prev     <= 1'b1;
      r_st       <= S_IDLE;
      r_div      <= DIV_W'(1);
      r_dcnt     <= '0;
      r_tcnt     <= '0;
      r_sh       <= '0;
      r_len      <= LEN_MIN;
      r_bit      <= '0;
      r_par_on   <= 1'b0;
      r_odd      <= 1'b0;
      r_pbit     <= 1'b0;
      r_stop2    <= 1'b0;
      r_second   <= 1'b0;
      r_ferr     <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
    end else begin
      r_s1       <= rx_line;
      r_s2       <= r_s1;
      r_prev     <= r_s2;
      rx_valid   <= 1'b0;
      rx_par_err <= 1'b0;
      rx_frm_err <= 1'b0;
      if (r_st == S_IDLE) begin
        if (r_fall) begin
          r_st     <= S_START;
          r_dcnt   <= '0;
          r_tcnt   <= '0;
          r_div    <= c_div;
          r_len    <= c_len;
          r_par_on <= c_par_on;
          r_odd    <= c_odd;
          r_stop2  <= cfg_stop2;
          r_sh     <= '0;
          r_bit    <= '0;
          r_second <= 1'b0;
          r_ferr   <= 1'b0;
        end
      end else begin
        r_dcnt <= r_tick ? '0 : r_dcnt + 1'b1;
        if (r_tick) begin
          if (r_st == S_START) begin
            if (r_tcnt == T_MID) begin
              r_tcnt <= '0;
              r_st   <= r_s2 ? S_IDLE : S_DATA;
            end else begin
              r_tcnt <= r_tcnt + 1'b1;
            end
          end else if (r_tcnt != T_LAST) begin
            r_tcnt <= r_tcnt + 1'b1;
          end else begin
            r_tcnt <= '0;
            case (r_st)
              S_DATA: begin
                r_sh  <= {r_s2, r_sh[DW-1:1]};
                r_bit <= r_bit + 1'b1;
                if (r_bit == r_len - 1'b1) r_st <= r_par_on ? S_PAR : S_STOP;
              end
              S_PAR: begin
                r_pbit <= r_s2;
                r_st   <= S_STOP;
              end
              S_STOP: begin
                if (r_stop2 && !r_second) begin
                  r_second <= 1'b1;
                  r_ferr   <= !r_s2;
                end else begin
                  rx_valid   <= 1'b1;
                  rx_data    <= r_sh >> (LEN_MAX - r_len);
                  rx_par_err <= r_par_on && (r_pbit != r_pexp);
                  rx_frm_err <= r_ferr || !r_s2;
                  r_st       <= S_IDLE;
                end
              end
              default: r_st <= S_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_line,
  input logic rx_valid,
  input logic rx_par_err,
  input logic rx_frm_err
);

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_line);

  a_r2_start_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_line);

  a_r4_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r11_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_par_err || rx_frm_err) |-> rx_valid);

endmodule

bind uart_xcvr uart_xcvr_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_line    (tx_line),
  .rx_valid   (rx_valid),
  .rx_par_err (rx_par_err),
  .rx_frm_err (rx_frm_err)
);

// File: tb/uart_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_xcvr_tb_top;

  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'(DIV);
  logic [3:0]  cfg_len = 4'd8;
  logic [1:0]  cfg_par = 2'b00;
  logic        cfg_stop2 = 1'b0;
  logic [8:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_line;
  logic        rx_line = 1'b1;
  logic [8:0]  rx_data;
  logic        rx_valid, rx_par_err, rx_frm_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  uart_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit par_bit(input logic [8:0] d, input int len, input logic [1:0] mode);
    bit p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    return (mode == 2'b10) ? ~p : p;
  endfunction

  task automatic set_cfg(input int len, input logic [1:0] par, input bit st2);
    @(negedge clk);
    cfg_len = 4'(len);
    cfg_par = par;
    cfg_stop2 = st2;
  endtask

  // transmit one word and sample the line at every mid-bit
  task automatic tx_frame(input logic [8:0] d, input int len, input logic [1:0] par,
                          input bit st2, input bit disturb, input string req);
    bit pon = (par == 2'b01) || (par == 2'b10);
    set_cfg(len, par, st2);
    tx_data = d;
    tx_valid = 1'b1;
    @(posedge clk); #1;
    tx_valid = 1'b0;
    chk(tx_line == 1'b0, {req, " R2 start edge"}, tx_line, 0);
    chk(tx_ready == 1'b0, {req, " R4 busy"}, tx_ready, 0);
    if (disturb) begin
      cfg_len = 4'd5; cfg_par = 2'b10; cfg_stop2 = ~st2; cfg_div = 16'd9;
      tx_data = ~d; tx_valid = 1'b1;
    end
    repeat (8 * DIV) @(posedge clk); #1;
    chk(tx_line == 1'b0, {req, " R2 start mid"}, tx_line, 0);
    for (int i = 0; i < len; i++) begin
      repeat (BIT) @(posedge clk); #1;
      chk(tx_line == d[i], $sformatf("%s R2 data bit %0d", req, i), tx_line, d[i]);
      if (disturb && i == 0) begin
        chk(tx_ready == 1'b0, {req, " R4 offer ignored while busy"}, tx_ready, 0);
        tx_valid = 1'b0;
      end
    end
    if (pon) begin
      repeat (BIT) @(posedge clk); #1;
      chk(tx_line == par_bit(d, len, par), {req, " R3 parity bit"}, tx_line, par_bit(d, len, par));
    end
    for (int s = 0; s < (st2 ? 2 : 1); s++) begin
      repeat (BIT) @(posedge clk); #1;
      chk(tx_line == 1'b1, $sformatf("%s R2 stop %0d", req, s), tx_line, 1);
    end
    repeat (8 * DIV) @(posedge clk); #1;
    chk(tx_ready == 1'b1 && tx_line == 1'b1, {req, " R1 idle after frame"},
        {tx_ready, tx_line}, 3);
    cfg_div = 16'(DIV);
  endtask

  // drive one character into rx_line and watch rx_valid
  task automatic rx_frame(input logic [8:0] d, input int len, input logic [1:0] par,
                          input bit st2, input int bitp, input bit flip_par,
                          input int bad_stop, input bit disturb, input string req);
    bit pon = (par == 2'b01) || (par == 2'b10);
    int nbits = 1 + len + (pon ? 1 : 0) + (st2 ? 2 : 1);
    int seen = 0;
    logic [8:0] gd = '0;
    logic gp = 1'b0, gf = 1'b0;
    logic [8:0] mask = 9'((1 << len) - 1);
    set_cfg(len, par, st2);
    fork
      begin
        rx_line = 1'b0;
        repeat (bitp) @(negedge clk);
        if (disturb) begin cfg_len = 4'd9; cfg_par = 2'b00; cfg_stop2 = 1'b1; cfg_div = 16'd7; end
        for (int i = 0; i < len; i++) begin
          rx_line = d[i];
          repeat (bitp) @(negedge clk);
        end
        if (pon) begin
          rx_line = par_bit(d, len, par) ^ flip_par;
          repeat (bitp) @(negedge clk);
        end
        for (int s = 1; s <= (st2 ? 2 : 1); s++) begin
          rx_line = (bad_stop == s) ? 1'b0 : 1'b1;
          repeat (bitp) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (2 * bitp) @(negedge clk);
      end
      begin
        for (int c = 0; c < (nbits + 2) * bitp; c++) begin
          @(negedge clk);
          if (rx_valid) begin
            seen++;
            gd = rx_data; gp = rx_par_err; gf = rx_frm_err;
          end
        end
      end
    join
    cfg_div = 16'(DIV);
    chk(seen == 1, {req, " R6 one valid pulse"}, seen, 1);
    chk(gd == (d & mask), {req, " R6 data"}, gd, d & mask);
    chk(gp == flip_par, {req, " R8 parity flag"}, gp, flip_par);
    chk(gf == (bad_stop != 0), {req, " R9 framing flag"}, gf, bad_stop != 0);
    chk(!rx_par_err && !rx_frm_err && !rx_valid, {req, " R11 flags idle"},
        {rx_valid, rx_par_err, rx_frm_err}, 0);
  endtask

  task automatic rx_glitch();
    int seen = 0;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (5 * DIV) @(negedge clk);
    rx_line = 1'b1;
    for (int c = 0; c < 40 * DIV; c++) begin
      @(negedge clk);
      if (rx_valid) seen++;
    end
    chk(seen == 0, "R7 glitch gives no character", seen, 0);
    rx_frame(9'h0C9, 8, 2'b00, 1'b0, BIT, 1'b0, 0, 1'b0, "R7 after glitch");
  endtask

  task automatic reset_check();
    repeat (3) @(posedge clk);
    #1;
    chk(tx_line == 1'b1, "R1 reset tx_line", tx_line, 1);
    chk(tx_ready == 1'b1, "R1 reset tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 reset rx_valid", rx_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1 && tx_ready == 1'b1, "R1 idle after reset", {tx_line, tx_ready}, 3);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    reset_check();
    tx_frame(9'h0A5, 8, 2'b00, 1'b0, 1'b0, "tx 8N1");
    tx_frame(9'h016, 5, 2'b01, 1'b0, 1'b0, "tx 5E1");
    tx_frame(9'h1C3, 9, 2'b10, 1'b1, 1'b0, "tx 9O2");
    tx_frame(9'h03C, 7, 2'b01, 1'b1, 1'b1, "tx R5 cfg change");
    rx_frame(9'h05A, 8, 2'b00, 1'b0, BIT, 1'b0, 0, 1'b0, "rx 8N1");
    rx_frame(9'h013, 5, 2'b10, 1'b0, BIT, 1'b0, 0, 1'b0, "rx 5O1");
    rx_frame(9'h155, 9, 2'b01, 1'b1, BIT, 1'b0, 0, 1'b0, "rx 9E2");
    rx_frame(9'h07E, 7, 2'b01, 1'b0, BIT, 1'b1, 0, 1'b0, "rx R8 bad parity");
    rx_frame(9'h0B1, 8, 2'b10, 1'b0, BIT, 1'b1, 0, 1'b0, "rx R8 bad odd parity");
    rx_frame(9'h081, 8, 2'b00, 1'b0, BIT, 1'b0, 1, 1'b0, "rx R9 low stop");
    rx_frame(9'h066, 8, 2'b00, 1'b1, BIT, 1'b0, 2, 1'b0, "rx R9 low second stop");
    rx_frame(9'h0E7, 6, 2'b01, 1'b0, BIT, 1'b0, 0, 1'b1, "rx R5 cfg change");
    rx_glitch();
    rx_frame(9'h0D3, 8, 2'b00, 1'b0, BIT - 2, 1'b0, 0, 1'b0, "rx R10 fast sender");
    rx_frame(9'h02C, 8, 2'b00, 1'b0, BIT + 2, 1'b0, 0, 1'b0, "rx R10 slow sender");
    summary();
    $finish;
  end

endmodule